// File: doc/BRIEF.md
# Word Bit Test-and-Modify Unit

This unit executes the four single-bit operations on a 16-bit word: test, test-and-set, test-and-reset and test-and-complement. The carry flag output always returns the selected bit as it was before the operation. Only the carry flag is produced. No other flag is touched.

An operand lives either in a register or in memory. For a register operand, the caller supplies the register value. The unit returns the modified word and a write-back strobe one cycle after `start_i`. For a memory operand, the unit runs a read-modify-write sequence through a simple request/acknowledge port. It reads one word, changes it, and writes it back to the same address. A plain test reads only.

The bit position comes from an offset operand. This operand is either an immediate or a register value. Every form takes the bit index from the offset's low four bits. When a register offset is used with a memory operand, the upper twelve bits are treated as a signed word displacement from the base address. An immediate memory form uses the base address unchanged.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o`, `mem_req_o`, `mem_we_o`, `reg_we_o`, `cf_o` and `result_o` are all 0 until the first operation.
- R2: A register-operand operation (`mem_form_i`=0) raises `done_o` in the cycle after `start_i` is sampled, with `cf_o` and `result_o` valid. It never raises `mem_req_o`. In the same cycle, `reg_we_o` is 1 for set, reset and complement and 0 for test.
- R3: For register operands and for immediate memory forms (`imm_form_i`=1), the bit index is `offset_i[3:0]`. Bits 15:4 of `offset_i` have no effect on the index, the result or the address.
- R4: `cf_o` equals the selected bit of the operand word before modification, in every form and operation.
- R5: `op_i` encodes 0 = test (word unchanged), 1 = set (bit forced to 1), 2 = reset (bit forced to 0) and 3 = complement (bit inverted). All other bits of `result_o` equal the original word.
- R6: A memory form with a register offset accesses address (`base_addr_i` + 2 * (`offset_i` arithmetically shifted right by 4)) AND `addr_mask_i`, so negative offsets reach words below the base. The bit index is `offset_i[3:0]`.
- R7: An immediate memory form accesses address `base_addr_i` AND `addr_mask_i`.
- R8: A memory form first issues a one-cycle read request (`mem_req_o`=1, `mem_we_o`=0). It then waits any number of cycles for `mem_ack_i`, and takes `mem_rdata_i` in the acknowledge cycle. For a modifying operation it then holds a write request (`mem_we_o`=1) carrying the modified word at the same address until `mem_ack_i`. `done_o` follows one cycle after that acknowledge.
- R9: A memory test issues no write request. `done_o` follows one cycle after the read acknowledge, and `result_o` shows the word read.
- R10: `start_i` is ignored while an operation is in progress. It starts no second access and does not change the operation, index or address in use.
- R11: `done_o` is a single-cycle pulse per operation. `reg_we_o` is 0 for every memory form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 2 | Operation: 0 test, 1 set, 2 reset, 3 complement |
| mem_form_i | input | 1 | 1 = operand word in memory, 0 = in register |
| imm_form_i | input | 1 | 1 = offset is an immediate, 0 = offset from a register |
| reg_val_i | input | 16 | Register operand word |
| offset_i | input | 16 | Bit offset operand |
| base_addr_i | input | AW | Base effective address of the memory operand |
| addr_mask_i | input | AW | Address-size mask applied to the memory address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| done_o | output | 1 | Operation complete (one-cycle pulse) |
| cf_o | output | 1 | Carry flag: prior value of the selected bit |
| result_o | output | 16 | Word after the operation |
| reg_we_o | output | 1 | Register write-back strobe |

## Verification
The embedded assertions check several properties on every cycle:
- the bit relation between `cf_o` and `result_o` at completion for each operation;
- that a test never produces a write, either to memory or to the register;
- that register forms never touch the memory port;
- that the read request lasts one cycle and the address holds through the sequence;
- that `done_o` is a pulse.

Other behaviours can only be shown by the bench's scenarios. These are the computed address (including negative displacement and masking), that high offset bits are ignored, that the memory array ends up with the right word, and that a `start_i` issued mid-sequence is ignored. The bench checks each of them against its own memory model and access counters.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_TEST  = 2'd0,
    OP_SET   = 2'd1,
    OP_RESET = 2'd2,
    OP_COMPL = 2'd3
  } bitop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE
  } bitop_state_e;
endpackage

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen #(
  parameter int W  = 16,
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic [W-1:0]  offset_i,
  input  logic          imm_i,
  output logic [AW-1:0] addr_o
);
  localparam int IDXW       = $clog2(W);
  localparam int BYTE_SHIFT = $clog2(W / 8);

  logic signed [W-1:0]  word_disp;
  logic signed [AW-1:0] word_disp_ext;
  logic [AW-1:0]        byte_disp;

  always_comb begin
    word_disp     = $signed(offset_i) >>> IDXW;
    word_disp_ext = AW'(word_disp);
    byte_disp     = AW'(word_disp_ext <<< BYTE_SHIFT);
    // immediate forms use the base address unchanged
    addr_o = (imm_i ? base_i : base_i + byte_disp) & mask_i;
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int W = 16,
  localparam int IDXW = $clog2(W)
) (
  input  logic [W-1:0]    word_i,
  input  logic [IDXW-1:0] idx_i,
  input  bitop_e          op_i,
  output logic            cf_o,
  output logic [W-1:0]    word_o
);
  assign cf_o = word_i[idx_i];

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic hit;
    assign hit = (idx_i == IDXW'(b));
    always_comb begin
      word_o[b] = word_i[b];
      if (hit) begin
        unique case (op_i)
          OP_SET:   word_o[b] = 1'b1;
          OP_RESET: word_o[b] = 1'b0;
          OP_COMPL: word_o[b] = ~word_i[b];
          default:  word_o[b] = word_i[b];
        endcase
      end
    end
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_form_i,
  input  logic mem_q_i,
  input  logic is_test_i,
  input  logic mem_ack_i,
  output logic idle_o,
  output logic accept_o,
  output logic load_reg_o,
  output logic load_mem_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic done_o
);
  bitop_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = mem_form_i ? ST_RD_REQ : ST_DONE;
      ST_RD_REQ:  state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_ack_i) state_d = is_test_i ? ST_DONE : ST_WR_REQ;
      ST_WR_REQ:  if (mem_ack_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign accept_o   = idle_o & start_i;
  assign load_reg_o = accept_o & ~mem_form_i;
  assign load_mem_o = (state_q == ST_RD_WAIT) & mem_ack_i;
  assign mem_req_o  = (state_q == ST_RD_REQ) | (state_q == ST_WR_REQ);
  assign mem_we_o   = (state_q == ST_WR_REQ);
  assign done_o     = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_RD_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !(mem_req_o && !mem_we_o)); // R8
  AST_TEST_NO_MEM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !is_test_i); // R9
  AST_REG_FORM_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_q_i); // R2
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          mem_form_i,
  input  logic          imm_form_i,
  input  logic [15:0]   reg_val_i,
  input  logic [15:0]   offset_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [AW-1:0] addr_mask_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          done_o,
  output logic          cf_o,
  output logic [15:0]   result_o,
  output logic          reg_we_o
);
  localparam int W    = 16;
  localparam int IDXW = $clog2(W);

  bitop_e          op_q;
  logic            mem_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   addr_q, addr_calc;
  logic            cf_q;
  logic [W-1:0]    word_q;

  logic idle, accept, load_reg, load_mem;

  bitop_e          alu_op;
  logic [IDXW-1:0] alu_idx;
  logic [W-1:0]    alu_word, alu_out;
  logic            alu_cf;

  bitop_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_form_i (mem_form_i),
    .mem_q_i    (mem_q),
    .is_test_i  (op_q == OP_TEST),
    .mem_ack_i  (mem_ack_i),
    .idle_o     (idle),
    .accept_o   (accept),
    .load_reg_o (load_reg),
    .load_mem_o (load_mem),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .done_o     (done_o)
  );

  bitop_addr_gen #(.W(W), .AW(AW)) u_addr (
    .base_i   (base_addr_i),
    .mask_i   (addr_mask_i),
    .offset_i (offset_i),
    .imm_i    (imm_form_i),
    .addr_o   (addr_calc)
  );

  // idle: register operand straight from the ports; otherwise the word read back
  always_comb begin
    alu_op   = idle ? bitop_e'(op_i) : op_q;
    alu_idx  = idle ? offset_i[IDXW-1:0] : idx_q;
    alu_word = idle ? reg_val_i : mem_rdata_i;
  end

  bitop_alu #(.W(W)) u_alu (
    .word_i (alu_word),
    .idx_i  (alu_idx),
    .op_i   (alu_op),
    .cf_o   (alu_cf),
    .word_o (alu_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_TEST;
      mem_q  <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      op_q   <= bitop_e'(op_i);
      mem_q  <= mem_form_i;
      idx_q  <= offset_i[IDXW-1:0];
      addr_q <= addr_calc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q   <= 1'b0;
      word_q <= '0;
    end else if (load_reg || load_mem) begin
      cf_q   <= alu_cf;
      word_q <= alu_out;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = word_q;
  assign cf_o        = cf_q;
  assign result_o    = word_q;
  assign reg_we_o    = done_o & ~mem_q & (op_q != OP_TEST);

  AST_SET_WRITES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_SET) |-> result_o[idx_q]); // R5
  AST_RESET_WRITES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_RESET) |-> !result_o[idx_q]); // R5
  AST_COMPL_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_COMPL) |-> (result_o[idx_q] != cf_o)); // R4
  AST_TEST_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_TEST) |-> (result_o[idx_q] == cf_o)); // R4
  AST_NO_REG_WE_ON_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (op_q != OP_TEST && !mem_q)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && $past(!idle)) |-> $stable(mem_addr_o)); // R10
  AST_WRITE_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_wdata_o)); // R8
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  localparam int AW = 16;
  localparam logic [1:0] T_TEST = 2'd0, T_SET = 2'd1, T_RST = 2'd2, T_CMP = 2'd3;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          start_i = 0;
  logic [1:0]    op_i = 0;
  logic          mem_form_i = 0, imm_form_i = 0;
  logic [15:0]   reg_val_i = 0, offset_i = 0;
  logic [AW-1:0] base_addr_i = 0, addr_mask_i = '1;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [15:0]   mem_wdata_o;
  logic [15:0]   mem_rdata_i = 0;
  logic          mem_ack_i = 0;
  logic          done_o, cf_o, reg_we_o;
  logic [15:0]   result_o;

  int checks = 0, fails = 0, cyc = 0;

  bitop_unit #(.AW(AW)) uut (.*);

  always #5 clk_i = ~clk_i;

  // memory model: 64 words, byte address bits [6:1]
  logic [15:0]   mem [64];
  int            lat = 0;
  int            rcnt = 0, wcnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic          rd_pend = 0;
  logic [AW-1:0] rd_addr = 0, last_rd = 0, last_wr = 0;

  always @(negedge clk_i) begin
    mem_ack_i <= 1'b0;
    if (rd_pend) begin
      if (rcnt == 0) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= mem[rd_addr[6:1]];
        rd_pend     <= 1'b0;
      end else rcnt <= rcnt - 1;
    end else if (mem_req_o && !mem_we_o) begin
      rd_pend <= 1'b1;
      rcnt    <= lat;
      wcnt    <= lat;
      rd_addr <= mem_addr_o;
      last_rd <= mem_addr_o;
      rd_cnt  <= rd_cnt + 1;
    end
    if (mem_req_o && mem_we_o && !mem_ack_i) begin
      if (wcnt == 0) begin
        mem_ack_i              <= 1'b1;
        mem[mem_addr_o[6:1]]   <= mem_wdata_o;
        last_wr                <= mem_addr_o;
        wr_cnt                 <= wr_cnt + 1;
      end else wcnt <= wcnt - 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modw(logic [1:0] op, logic [15:0] w, logic [3:0] b);
    case (op)
      T_SET:   return w | (16'h1 << b);
      T_RST:   return w & ~(16'h1 << b);
      T_CMP:   return w ^ (16'h1 << b);
      default: return w;
    endcase
  endfunction

  task automatic t_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    chk("R1 done", done_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 we", mem_we_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 cf", cf_o, 0);
    chk("R1 result", result_o, 0);
    chk("R1 reg_we", reg_we_o, 0);
  endtask

  // register operand: done expected one cycle after start is sampled
  task automatic t_reg(logic [1:0] op, logic [15:0] w, logic [15:0] off, logic imm);
    logic [3:0] b = off[3:0];
    @(negedge clk_i);
    op_i = op; reg_val_i = w; offset_i = off; imm_form_i = imm; mem_form_i = 0;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk("R2 done", done_o, 1);
    chk("R2 no mem req", mem_req_o, 0);
    chk("R2 reg_we", reg_we_o, op != T_TEST);
    chk("R4 cf", cf_o, w[b]);
    chk("R3 R5 result", result_o, modw(op, w, b));
    @(negedge clk_i);
    chk("R11 done pulse", done_o, 0);
  endtask

  // memory operand; busy_poke issues a second start mid-sequence (R10)
  task automatic t_mem(logic [1:0] op, logic imm, logic [AW-1:0] base, logic [15:0] off,
                       logic [AW-1:0] mask, int l, logic [15:0] init, bit busy_poke);
    logic [3:0]    b = off[3:0];
    logic [AW-1:0] disp = AW'($signed(off) >>> 4);
    logic [AW-1:0] ea = (imm ? base : base + (disp << 1)) & mask;
    int r0 = rd_cnt, w0 = wr_cnt, n = 0;
    mem[ea[6:1]] = init;
    lat = l;
    @(negedge clk_i);
    op_i = op; imm_form_i = imm; base_addr_i = base; offset_i = off; addr_mask_i = mask;
    mem_form_i = 1; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    if (busy_poke) begin
      @(negedge clk_i);
      op_i = T_CMP; offset_i = 16'h0042; base_addr_i = 16'h0010; start_i = 1;
      @(negedge clk_i);
      start_i = 0;
    end
    while (!done_o && n < 60) begin
      @(negedge clk_i);
      n++;
    end
    chk("R8 done seen", done_o, 1);
    chk("R11 no reg_we for memory", reg_we_o, 0);
    chk("R4 cf", cf_o, init[b]);
    chk("R5 result", result_o, modw(op, init, b));
    chk(imm ? "R7 read addr" : "R6 read addr", last_rd, ea);
    chk("R10 one read", rd_cnt - r0, 1);
    if (op == T_TEST) begin
      chk("R9 no write", wr_cnt - w0, 0);
    end else begin
      chk("R8 one write", wr_cnt - w0, 1);
      chk("R8 write addr", last_wr, ea);
    end
    chk("R5 memory word", mem[ea[6:1]], modw(op, init, b));
    @(negedge clk_i);
    chk("R11 done pulse", done_o, 0);
    chk("R8 idle req", mem_req_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    t_reset();
    t_reg(T_TEST, 16'h8001, 16'h000F, 1'b0);
    t_reg(T_SET,  16'h0000, 16'hFFF7, 1'b1);   // R3 high bits ignored
    t_reg(T_RST,  16'hFFFF, 16'h1230, 1'b0);   // R3 index 0
    t_reg(T_CMP,  16'hA5A5, 16'h7F02, 1'b1);
    t_reg(T_CMP,  16'hA5A5, 16'h0002, 1'b0);   // R3 same result as above
    t_mem(T_SET,  1'b0, 16'h0040, 16'h0023, 16'hFFFF, 0, 16'h0000, 0); // R6 +2 words
    t_mem(T_RST,  1'b0, 16'h0040, 16'hFFE5, 16'hFFFF, 2, 16'hFFFF, 0); // R6 -2 words
    t_mem(T_CMP,  1'b0, 16'h1050, 16'h0023, 16'h007F, 1, 16'h1234, 0); // R6 masked
    t_mem(T_TEST, 1'b0, 16'h0030, 16'h0019, 16'hFFFF, 3, 16'h0200, 0); // R9
    t_mem(T_SET,  1'b1, 16'h0020, 16'hFFF3, 16'hFFFF, 0, 16'h0001, 0); // R7
    t_mem(T_TEST, 1'b1, 16'h10A4, 16'h8008, 16'h00FF, 1, 16'h0100, 0); // R7 R9
    t_mem(T_RST,  1'b0, 16'h0060, 16'h0014, 16'hFFFF, 4, 16'h00F0, 1); // R10
    t_reg(T_SET,  16'h0F0F, 16'h0004, 1'b0);   // R2 after memory ops
    summary();
  end
endmodule